// File: doc/BRIEF.md
# Segmented Address Translator

This block turns a logical address, made of a segment selector and a 32-bit offset, into a linear address. A single control input picks the mode. With protection disabled, the selector is scaled by sixteen and added to the offset, with no checks. With protection enabled, the selector's index picks an 8-byte descriptor from a table in memory. That table is located by a base and limit register inside the block. The descriptor's base is added to the offset, and the offset is compared with the descriptor's limit.

The block keeps one selector and one cached descriptor. A descriptor is read over a valid/ready request port with a separate response strobe, and is read again only after the selector is reloaded. The block also holds the current privilege level and reports it. Only level 0 may rewrite the table register. Every accepted translation ends in exactly one result pulse: either a linear address or a fault with a cause code.

Top module: `seg_xlate`

## Requirements
- R1: With `prot_en` low when a request is accepted, `xl_vld` pulses exactly one cycle later with `xl_addr` = selector × 16 + offset (modulo 2^32), and no fault is raised.
- R2: With `prot_en` high and the offset strictly below the descriptor limit, `xl_vld` pulses with `xl_addr` = descriptor base + offset.
- R3: With `prot_en` high and offset ≥ descriptor limit, `flt_vld` pulses with `flt_code` = 1 (limit) and `xl_vld` stays low. `xl_vld` and `flt_vld` are never high together, and `flt_code` is nonzero whenever `flt_vld` is high.
- R4: The selector index is `sel_in[15:3]`; bits 2:0 do not affect translation. The descriptor sits at table base + index × 8. Its word at +0 is the segment base and its word at +4 is the segment limit. They are read as two separate memory requests, +0 first.
- R5: If index × 8 is greater than the table limit, `flt_vld` pulses with `flt_code` = 2 (table bounds) and no memory request is made.
- R6: A table-register write while the privilege level is not 0 raises `flt_vld` with `flt_code` = 3 (privileged write) one cycle later, and leaves the table base and limit unchanged.
- R7: `cpl` shows the value last loaded through `cpl_ld`/`cpl_in` and is 0 after reset.
- R8: After a descriptor is fetched, further protected translations with the same selector make no memory request. Reloading the selector forces a new two-word fetch.
- R9: While `mem_req_vld` is high and `mem_req_rdy` is low, the request stays asserted and `mem_req_addr` stays stable.
- R10: After reset, `req_rdy` is 1, `cpl` is 0, and `xl_vld`, `flt_vld` and `mem_req_vld` are 0.
- R11: The mode is taken from `prot_en` at the moment each request is accepted, so the same selector gives a shift-and-add result in one mode and a table result in the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prot_en | input | 1 | Protection enable; sampled when a request is accepted |
| sel_ld | input | 1 | Load the selector from `sel_in` (taken while `req_rdy`) |
| sel_in | input | 16 | New selector value |
| cpl_ld | input | 1 | Load the privilege level from `cpl_in` |
| cpl_in | input | 2 | New privilege level (0 kernel, 3 user) |
| tbl_wr | input | 1 | Write the table base and limit |
| tbl_base_in | input | 32 | New table base |
| tbl_lim_in | input | 16 | New table limit |
| req_vld | input | 1 | Translation request |
| req_off | input | 32 | Logical offset |
| req_rdy | output | 1 | Block idle and able to accept a request |
| xl_vld | output | 1 | Linear address valid pulse |
| xl_addr | output | 32 | Linear address |
| flt_vld | output | 1 | Fault pulse |
| flt_code | output | 2 | Fault cause: 1 limit, 2 table bounds, 3 privileged write |
| cpl | output | 2 | Current privilege level |
| mem_req_vld | output | 1 | Memory read request |
| mem_req_addr | output | 32 | Memory read address |
| mem_req_rdy | input | 1 | Memory accepts the request |
| mem_rsp_vld | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |

## Verification
Real-mode vectors include a selector and offset whose sum wraps past 2^32. These show that the shift-and-add path drops the carry and takes a single cycle. Protected-mode vectors place offsets just below, at, and far above a descriptor's limit, which separates the strict-less-than comparison from an off-by-one. They also use selectors with nonzero low bits and an index just outside the table, which confirms that only bits 15:3 are used and that the bounds fault stops any memory traffic. Counting memory handshakes across repeated and reloaded selectors shows when the cached descriptor is reused. A write made at user level, followed by a translation that depends on the old table limit, shows the write had no effect.

// File: rtl/seg_pkg.sv
package seg_pkg;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_LIMIT = 2'd1,
        FLT_TABLE = 2'd2,
        FLT_PRIV  = 2'd3
    } flt_e;

    typedef enum logic [2:0] {
        F_IDLE  = 3'd0,
        F_REQ0  = 3'd1,
        F_WAIT0 = 3'd2,
        F_REQ1  = 3'd3,
        F_WAIT1 = 3'd4
    } fst_e;

    typedef enum logic {
        T_IDLE  = 1'b0,
        T_FETCH = 1'b1
    } tst_e;

endpackage

// File: rtl/seg_dtr.sv
module seg_dtr #(
    parameter int AW  = 32,
    parameter int TLW = 16,
    parameter int PW  = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tbl_wr,
    input  logic [AW-1:0]  tbl_base_in,
    input  logic [TLW-1:0] tbl_lim_in,
    input  logic           cpl_ld,
    input  logic [PW-1:0]  cpl_in,
    output logic [AW-1:0]  tbl_base,
    output logic [TLW-1:0] tbl_lim,
    output logic [PW-1:0]  cpl,
    output logic           priv_flt
);

    typedef struct packed {
        logic [AW-1:0]  base;
        logic [TLW-1:0] lim;
        logic [PW-1:0]  cpl;
    } dtr_t;

    dtr_t d, q;

    always_comb begin
        d        = q;
        priv_flt = 1'b0;
        if (cpl_ld) begin
            d.cpl = cpl_in;
        end
        if (tbl_wr) begin
            if (q.cpl == '0) begin
                d.base = tbl_base_in;
                d.lim  = tbl_lim_in;
            end else begin
                priv_flt = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign tbl_base = q.base;
    assign tbl_lim  = q.lim;
    assign cpl      = q.cpl;

    p_priv_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_wr && cpl != '0) |=> ($stable(tbl_base) && $stable(tbl_lim)));

    p_cpl_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_ld |=> (cpl == $past(cpl_in)));

endmodule

// File: rtl/seg_fetch.sv
module seg_fetch
    import seg_pkg::*;
#(
    parameter int AW = 32,
    parameter int IW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inval,
    input  logic          go,
    input  logic [IW-1:0] idx,
    input  logic [AW-1:0] tbl_base,
    output logic          mem_req_vld,
    output logic [AW-1:0] mem_req_addr,
    input  logic          mem_req_rdy,
    input  logic          mem_rsp_vld,
    input  logic [AW-1:0] mem_rsp_data,
    output logic [AW-1:0] d_base,
    output logic [AW-1:0] d_lim,
    output logic          d_vld
);

    localparam int DESC_B = 8;
    localparam int WORD_B = 4;

    typedef struct packed {
        fst_e          st;
        logic [AW-1:0] addr;
        logic [AW-1:0] base;
        logic [AW-1:0] lim;
        logic          vld;
    } fch_t;

    fch_t d, q;

    always_comb begin
        d = q;
        if (inval) begin
            d.vld = 1'b0;
        end
        case (q.st)
            F_IDLE: begin
                if (go) begin
                    d.addr = tbl_base + AW'(idx) * AW'(DESC_B);
                    d.st   = F_REQ0;
                end
            end
            F_REQ0: begin
                if (mem_req_rdy) d.st = F_WAIT0;
            end
            F_WAIT0: begin
                if (mem_rsp_vld) begin
                    d.base = mem_rsp_data;
                    d.addr = q.addr + AW'(WORD_B);
                    d.st   = F_REQ1;
                end
            end
            F_REQ1: begin
                if (mem_req_rdy) d.st = F_WAIT1;
            end
            F_WAIT1: begin
                if (mem_rsp_vld) begin
                    d.lim = mem_rsp_data;
                    d.vld = 1'b1;
                    d.st  = F_IDLE;
                end
            end
            default: d.st = F_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: F_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign mem_req_vld  = (q.st == F_REQ0) || (q.st == F_REQ1);
    assign mem_req_addr = q.addr;
    assign d_base       = q.base;
    assign d_lim        = q.lim;
    assign d_vld        = q.vld;

    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_vld && !mem_req_rdy) |=> (mem_req_vld && $stable(mem_req_addr)));

    p_fill_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(d_vld) |-> $past(mem_rsp_vld));

    p_word_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == F_REQ1 && $past(q.st) == F_WAIT0) |-> (mem_req_addr == $past(mem_req_addr) + AW'(WORD_B)));

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_pkg::*;
#(
    parameter int AW  = 32,
    parameter int SW  = 16,
    parameter int TLW = 16,
    parameter int PW  = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           prot_en,
    input  logic           sel_ld,
    input  logic [SW-1:0]  sel_in,
    input  logic           cpl_ld,
    input  logic [PW-1:0]  cpl_in,
    input  logic           tbl_wr,
    input  logic [AW-1:0]  tbl_base_in,
    input  logic [TLW-1:0] tbl_lim_in,
    input  logic           req_vld,
    input  logic [AW-1:0]  req_off,
    output logic           req_rdy,
    output logic           xl_vld,
    output logic [AW-1:0]  xl_addr,
    output logic           flt_vld,
    output logic [1:0]     flt_code,
    output logic [PW-1:0]  cpl,
    output logic           mem_req_vld,
    output logic [AW-1:0]  mem_req_addr,
    input  logic           mem_req_rdy,
    input  logic           mem_rsp_vld,
    input  logic [AW-1:0]  mem_rsp_data
);

    localparam int RPL_W  = 3;
    localparam int IW     = SW - RPL_W;
    localparam int RSHIFT = 4;

    typedef struct packed {
        tst_e          st;
        logic [SW-1:0] sel;
        logic [AW-1:0] off;
        logic          xv;
        logic [AW-1:0] xa;
        logic          fv;
        flt_e          fc;
    } xl_t;

    xl_t d, q;

    logic [AW-1:0]  tbl_base;
    logic [TLW-1:0] tbl_lim;
    logic           priv_flt;
    logic [AW-1:0]  d_base, d_lim;
    logic           d_vld;
    logic           go, inval;
    logic [IW-1:0]  idx;
    logic           tbl_oob;

    seg_dtr #(.AW(AW), .TLW(TLW), .PW(PW)) u_dtr (
        .clk         (clk),
        .rst_n       (rst_n),
        .tbl_wr      (tbl_wr),
        .tbl_base_in (tbl_base_in),
        .tbl_lim_in  (tbl_lim_in),
        .cpl_ld      (cpl_ld),
        .cpl_in      (cpl_in),
        .tbl_base    (tbl_base),
        .tbl_lim     (tbl_lim),
        .cpl         (cpl),
        .priv_flt    (priv_flt)
    );

    seg_fetch #(.AW(AW), .IW(IW)) u_fetch (
        .clk          (clk),
        .rst_n        (rst_n),
        .inval        (inval),
        .go           (go),
        .idx          (idx),
        .tbl_base     (tbl_base),
        .mem_req_vld  (mem_req_vld),
        .mem_req_addr (mem_req_addr),
        .mem_req_rdy  (mem_req_rdy),
        .mem_rsp_vld  (mem_rsp_vld),
        .mem_rsp_data (mem_rsp_data),
        .d_base       (d_base),
        .d_lim        (d_lim),
        .d_vld        (d_vld)
    );

    assign idx     = q.sel[SW-1:RPL_W];
    assign tbl_oob = ({AW'(idx), 3'b000} > {3'b000, AW'(tbl_lim)});
    assign inval   = sel_ld && (q.st == T_IDLE);

    always_comb begin
        d    = q;
        d.xv = 1'b0;
        d.xa = '0;
        d.fv = 1'b0;
        d.fc = FLT_NONE;
        go   = 1'b0;
        case (q.st)
            T_IDLE: begin
                if (sel_ld) d.sel = sel_in;
                if (req_vld) begin
                    d.off = req_off;
                    if (!prot_en) begin
                        d.xv = 1'b1;
                        d.xa = (AW'(q.sel) << RSHIFT) + req_off;
                    end else if (tbl_oob) begin
                        d.fv = 1'b1;
                        d.fc = FLT_TABLE;
                    end else if (d_vld) begin
                        if (req_off < d_lim) begin
                            d.xv = 1'b1;
                            d.xa = d_base + req_off;
                        end else begin
                            d.fv = 1'b1;
                            d.fc = FLT_LIMIT;
                        end
                    end else begin
                        go   = 1'b1;
                        d.st = T_FETCH;
                    end
                end
            end
            T_FETCH: begin
                if (d_vld) begin
                    d.st = T_IDLE;
                    if (q.off < d_lim) begin
                        d.xv = 1'b1;
                        d.xa = d_base + q.off;
                    end else begin
                        d.fv = 1'b1;
                        d.fc = FLT_LIMIT;
                    end
                end
            end
            default: d.st = T_IDLE;
        endcase
        if (priv_flt && !d.xv && !d.fv) begin
            d.fv = 1'b1;
            d.fc = FLT_PRIV;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: T_IDLE, fc: FLT_NONE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign req_rdy  = (q.st == T_IDLE);
    assign xl_vld   = q.xv;
    assign xl_addr  = q.xa;
    assign flt_vld  = q.fv;
    assign flt_code = q.fc;

    p_real_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_rdy && !prot_en && !sel_ld) |=>
        (xl_vld && !flt_vld && xl_addr == ({$past(q.sel), 4'b0000} + $past(req_off))));

    p_one_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(xl_vld && flt_vld));

    p_code_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flt_vld |-> (flt_code != FLT_NONE));

    p_no_mem_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_vld && flt_code == FLT_TABLE) |-> !mem_req_vld);

    p_priv_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_wr && cpl != '0 && !req_vld && req_rdy) |=> (flt_vld && flt_code == FLT_PRIV));

    p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_vld |-> !req_rdy);

endmodule

// File: tb/sim_seg_xlate.sv
`timescale 1ns/1ps
module sim_seg_xlate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prot_en = 1'b0;
    logic        sel_ld = 1'b0;
    logic [15:0] sel_in = '0;
    logic        cpl_ld = 1'b0;
    logic [1:0]  cpl_in = '0;
    logic        tbl_wr = 1'b0;
    logic [31:0] tbl_base_in = '0;
    logic [15:0] tbl_lim_in = '0;
    logic        req_vld = 1'b0;
    logic [31:0] req_off = '0;
    logic        req_rdy, xl_vld, flt_vld, mem_req_vld;
    logic [31:0] xl_addr, mem_req_addr;
    logic [1:0]  flt_code, cpl;
    logic        mem_rdy = 1'b0;
    logic        mem_rsp_vld = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int checks = 0;
    int errors = 0;
    int hs_cnt = 0;
    int hold_viol = 0;
    logic [31:0] hs_a0 = '0, hs_a1 = '0;
    logic        stall_q = 1'b0;
    logic [31:0] stall_addr = '0;

    always #2 clk = ~clk;

    seg_xlate u0 (
        .clk(clk), .rst_n(rst_n), .prot_en(prot_en), .sel_ld(sel_ld), .sel_in(sel_in),
        .cpl_ld(cpl_ld), .cpl_in(cpl_in), .tbl_wr(tbl_wr), .tbl_base_in(tbl_base_in),
        .tbl_lim_in(tbl_lim_in), .req_vld(req_vld), .req_off(req_off), .req_rdy(req_rdy),
        .xl_vld(xl_vld), .xl_addr(xl_addr), .flt_vld(flt_vld), .flt_code(flt_code),
        .cpl(cpl), .mem_req_vld(mem_req_vld), .mem_req_addr(mem_req_addr),
        .mem_req_rdy(mem_rdy), .mem_rsp_vld(mem_rsp_vld), .mem_rsp_data(mem_rsp_data)
    );

    localparam logic [31:0] TBASE = 32'h0000_2000;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [31:0] o;
        o = a - TBASE;
        return o[2] ? (32'h100 + (o >> 3) * 32'h10) : (32'h0040_0000 + (o >> 3) * 32'h1000);
    endfunction

    // memory model: ready toggles each cycle, response one cycle after handshake
    always @(posedge clk) begin
        mem_rdy      <= ~mem_rdy;
        mem_rsp_vld  <= mem_req_vld && mem_rdy;
        mem_rsp_data <= mem_word(mem_req_addr);
        if (mem_req_vld && mem_rdy) begin
            hs_cnt <= hs_cnt + 1;
            hs_a0  <= hs_a1;
            hs_a1  <= mem_req_addr;
        end
        if (stall_q && (!mem_req_vld || mem_req_addr != stall_addr)) hold_viol <= hold_viol + 1;
        stall_q    <= mem_req_vld && !mem_rdy;
        stall_addr <= mem_req_addr;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load_sel(input logic [15:0] s);
        @(negedge clk); sel_ld = 1'b1; sel_in = s;
        @(negedge clk); sel_ld = 1'b0;
    endtask

    task automatic xlate(input logic p, input logic [31:0] off,
                         output logic ok, output logic fv, output logic [1:0] fc,
                         output logic [31:0] addr, output int n);
        @(negedge clk);
        while (!req_rdy) @(negedge clk);
        req_vld = 1'b1; prot_en = p; req_off = off;
        @(negedge clk); req_vld = 1'b0;
        n = 1;
        while (!(xl_vld || flt_vld) && n < 60) begin @(negedge clk); n++; end
        ok = xl_vld; fv = flt_vld; fc = flt_code; addr = xl_addr;
    endtask

    // {prot, sel, off, kind(0 addr,1 limit,2 table), addr}
    localparam int NV = 10;
    localparam logic [82:0] VEC [NV] = '{
        {1'b0, 16'h1234, 32'h0000_0010, 2'd0, 32'h0001_2350},
        {1'b0, 16'hFFFF, 32'hFFFF_FFF0, 2'd0, 32'h000F_FFE0},
        {1'b0, 16'h0000, 32'h0000_0005, 2'd0, 32'h0000_0005},
        {1'b1, 16'h0008, 32'h0000_0020, 2'd0, 32'h0040_1020},
        {1'b1, 16'h0008, 32'h0000_010F, 2'd0, 32'h0040_110F},
        {1'b1, 16'h0008, 32'h0000_0110, 2'd1, 32'h0},
        {1'b1, 16'h003B, 32'h0000_0000, 2'd0, 32'h0040_7000},
        {1'b1, 16'h0040, 32'h0000_0000, 2'd2, 32'h0},
        {1'b1, 16'h0000, 32'h0000_00FF, 2'd0, 32'h0040_00FF},
        {1'b1, 16'h0010, 32'hFFFF_FFFF, 2'd1, 32'h0}
    };

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic ok, fv; logic [1:0] fc; logic [31:0] a; int n; int h0;
        repeat (4) @(negedge clk);
        // R10 reset state
        chk(req_rdy && !xl_vld && !flt_vld && !mem_req_vld && cpl == 2'd0, "R10 reset outputs",
            {27'd0, req_rdy, xl_vld, flt_vld, mem_req_vld, cpl[0]}, 32'h10);
        rst_n = 1'b1;
        @(negedge clk);
        tbl_wr = 1'b1; tbl_base_in = TBASE; tbl_lim_in = 16'h003F;
        @(negedge clk); tbl_wr = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [82:0] v;
            v = VEC[i];
            load_sel(v[81:66]);
            h0 = hs_cnt;
            xlate(v[82], v[65:34], ok, fv, fc, a, n);
            case (v[33:32])
                2'd0: begin
                    chk(ok && !fv && a == v[31:0], v[82] ? "R2 protected address" : "R1 real address", a, v[31:0]);
                    if (!v[82]) chk(n == 1, "R1 one-cycle latency", n, 1);
                    if (i == 6) chk(a == v[31:0], "R4 low selector bits ignored", a, v[31:0]);
                end
                2'd1: chk(fv && !ok && fc == 2'd1, "R3 limit fault", {30'd0, fc}, 1);
                default: begin
                    chk(fv && !ok && fc == 2'd2, "R5 table fault", {30'd0, fc}, 2);
                    chk(hs_cnt == h0, "R5 no memory request", hs_cnt - h0, 0);
                end
            endcase
        end

        // R8 caching and R4 fetch order
        load_sel(16'h0008);
        h0 = hs_cnt;
        xlate(1'b1, 32'h4, ok, fv, fc, a, n);
        chk(ok && a == 32'h0040_1004, "R2 after reload", a, 32'h0040_1004);
        chk(hs_cnt - h0 == 2, "R8 fetch two words", hs_cnt - h0, 2);
        chk(hs_a0 == 32'h2008 && hs_a1 == 32'h200C, "R4 fetch order", hs_a1, 32'h200C);
        h0 = hs_cnt;
        xlate(1'b1, 32'h8, ok, fv, fc, a, n);
        chk(ok && a == 32'h0040_1008, "R8 cached result", a, 32'h0040_1008);
        chk(hs_cnt == h0, "R8 no refetch", hs_cnt - h0, 0);
        load_sel(16'h0010);
        h0 = hs_cnt;
        xlate(1'b1, 32'h5, ok, fv, fc, a, n);
        chk(ok && a == 32'h0040_2005, "R8 reload result", a, 32'h0040_2005);
        chk(hs_cnt - h0 == 2 && hs_a0 == 32'h2010, "R8 refetch after reload", hs_a0, 32'h2010);

        // R11 mode switch on same selector
        xlate(1'b0, 32'h5, ok, fv, fc, a, n);
        chk(ok && a == 32'h0000_0105, "R11 real mode same selector", a, 32'h105);
        xlate(1'b1, 32'h5, ok, fv, fc, a, n);
        chk(ok && a == 32'h0040_2005, "R11 back to protected", a, 32'h0040_2005);

        // R7 and R6 privileged write
        @(negedge clk); cpl_ld = 1'b1; cpl_in = 2'd3;
        @(negedge clk); cpl_ld = 1'b0;
        chk(cpl == 2'd3, "R7 cpl user", {30'd0, cpl}, 3);
        tbl_wr = 1'b1; tbl_base_in = 32'h9000; tbl_lim_in = 16'hFFFF;
        @(negedge clk); tbl_wr = 1'b0;
        chk(flt_vld && flt_code == 2'd3 && !xl_vld, "R6 privileged write fault", {30'd0, flt_code}, 3);
        load_sel(16'h0040);
        xlate(1'b1, 32'h0, ok, fv, fc, a, n);
        chk(fv && fc == 2'd2, "R6 table unchanged", {30'd0, fc}, 2);
        @(negedge clk); cpl_ld = 1'b1; cpl_in = 2'd0;
        @(negedge clk); cpl_ld = 1'b0;
        chk(cpl == 2'd0, "R7 cpl kernel", {30'd0, cpl}, 0);

        chk(hold_viol == 0, "R9 request held while stalled", hold_viol, 0);

        repeat (3) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule